// File: doc/BRIEF.md
# Reset Source Classifier and Sequencer

This block is the reset controller of a microcontroller core. It watches an active-low external reset pin and a mode pin. The mode pin chooses how a pin reset is handled. When the mode pin is low, the reset acts at once and aborts any bus activity. When the mode pin is high, the block waits a short grace window so that the current access can finish. The block also accepts watchdog-overflow and software-reset requests. It works out which of five sources caused each reset and records that source in one-hot status flags. After that it holds the core in reset for a fixed-length sequence.

For a synchronous pin reset, the number of cycles the pin was sampled low decides between a short and a long reset. A long reset latches the whole start-up configuration word. A short reset latches the word but keeps the previous clock-select field, so the core keeps its clock frequency. While the sequence runs, the block can pull the reset pin low, as an open-drain driver, to notify external devices. The pin level seen on `rstin_i` is assumed to be already synchronized to `clk` and to come only from external drivers. The bus is represented by a single `busy_i` level. The power-on reset `rst_n` is synchronous and active low.

Top module: `reset_sequencer`

## Requirements
- R1: When `mode_i`=0 and `rstin_i`=0, `core_rst_o`, `abort_o` and `hold_cancel_o` are 1 in the same cycle, with no clock edge needed. `core_rst_o` is still 1 in the cycle after any clock edge that sampled this condition. `abort_o` is never 1 while `mode_i`=1.
- R2: An asynchronous pin reset sets the flags to exactly 5'b00001. The flag bit positions are: bit0 asynchronous, bit1 long, bit2 short, bit3 watchdog, bit4 software. When the pin is released, the sequence starts on the next edge.
- R3: With `mode_i`=1, a low pulse of at most MIN_CLKS sampled cycles has no effect. It causes no internal reset, no flag and no configuration change.
- R4: With `mode_i`=1, `hold_cancel_o` is 1 from the edge that samples the (MIN_CLKS+1)-th low cycle. `core_rst_o` follows on the first later edge where `busy_i`=0, and no later than GRACE_CLKS edges after `hold_cancel_o` rises.
- R5: When the pin is released, a synchronous pulse of more than MIN_CLKS+LONG_CLKS low samples sets the long flag (5'b00010). A shorter one of more than MIN_CLKS samples sets the short flag (5'b00100). The width counter saturates, so any longer pulse is still classified as long.
- R6: A long or asynchronous reset latches all of `cfg_pins_i`. A short reset latches bits [12:0] and keeps the previous bits [15:13], which form the clock-select field.
- R7: A watchdog request sets 5'b01000 and a software request sets 5'b10000. When both arrive together, the watchdog wins. Each one starts the sequence without changing the configuration.
- R8: After the pin is released, or after a request is taken, `core_rst_o` stays 1 for exactly SEQ_LEN cycles.
- R9: `rst_pull_o` is 1 only during the sequence and only when `bidir_en_i`=1. It stays 0 for watchdog and software resets while `mode_i`=0.
- R10: The flags are one-hot or zero. A 1 in `flag_clr_i` clears that flag bit. A new reset event in the same cycle takes priority over the clear.
- R11: While `rst_n`=0, `core_rst_o`=1, the flags are 5'b00001 and the configuration follows `cfg_pins_i`. After `rst_n` rises, `core_rst_o` stays 1 for SEQ_LEN cycles.
- R12: Watchdog and software requests that arrive during a running sequence are ignored. They neither change the flags nor lengthen the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| rstin_i | input | 1 | Synchronized external reset pin level, active low |
| mode_i | input | 1 | Reset mode: 0 asynchronous, 1 synchronous |
| sw_req_i | input | 1 | Software reset request pulse |
| wdt_req_i | input | 1 | Watchdog overflow pulse |
| bidir_en_i | input | 1 | Enables pulling the reset pin low during the sequence |
| busy_i | input | 1 | An internal access is in progress |
| cfg_pins_i | input | CFG_W | Start-up configuration word |
| flag_clr_i | input | 5 | Write-ones clear of the source flags |
| core_rst_o | output | 1 | Internal reset active |
| abort_o | output | 1 | Abort the current bus cycles immediately |
| hold_cancel_o | output | 1 | Cancel pending hold states |
| rst_pull_o | output | 1 | Open-drain pull-down enable for the reset pin |
| cfg_o | output | CFG_W | Latched configuration word |
| flags_o | output | 5 | One-hot reset source flags |

## Verification
Some properties are checked on every cycle:
- The flags stay one-hot or zero.
- The pulse-width count only grows while the pin stays low.
- A partial latch never moves the clock-select field.
- The sequence keeps the core in reset until its last count.
- The pull-down is never active outside an enabled sequence.
- The grace window ends as soon as the bus goes idle.
- An asynchronous condition keeps the core in reset past the clock edge.

Other behaviour needs the bench's scenarios. The sweep over every pulse width across the short/long boundaries confirms the classification and the exact configuration bits latched. The bench also measures:
- the exact cycle counts of the grace window and of the sequence;
- that a too-short pulse leaves everything untouched;
- the watchdog-over-software priority;
- that requests arriving mid-sequence are ignored.

// File: rtl/rstseq_pkg.sv
// Shared definitions of the reset sequencer: controller states,
// source flag positions and configuration latch operations.
package rstseq_pkg;

    // Controller states
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a reset event
        ST_GRACE,  // synchronous: hold states cancelled, access finishing
        ST_HOLD,   // synchronous: core in reset, pin still low
        ST_SEQ,    // fixed-length internal reset sequence
        ST_ASYNC   // asynchronous pin reset active
    } seq_state_e;

    // Number of reset sources and their flag bit positions
    localparam int NSRC      = 5;
    localparam int SRC_ASYNC = 0;
    localparam int SRC_LONG  = 1;
    localparam int SRC_SHORT = 2;
    localparam int SRC_WDT   = 3;
    localparam int SRC_SW    = 4;

    // Configuration latch operations
    typedef enum logic [1:0] {
        CFG_KEEP,  // leave the latched word unchanged
        CFG_FULL,  // latch the whole word
        CFG_PART   // latch the word but keep the clock-select field
    } cfg_op_e;

endpackage

// File: rtl/rstseq_width.sv
// Pulse width counter for the reset pin.
// Counts the consecutive cycles the pin is sampled low and saturates one
// step past the long-reset threshold. It reports whether the minimum width
// has been reached and whether the pulse counts as long.
// Assumes the pin level is already synchronized to clk.
module rstseq_width #(
    parameter int MIN_CLKS  = 25,
    parameter int LONG_CLKS = 522
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_low_i,
    output logic at_min_o,
    output logic is_long_o
);
    localparam int LONG_TH = MIN_CLKS + LONG_CLKS;
    localparam int CW      = $clog2(LONG_TH + 2);
    localparam logic [CW-1:0] SAT_VAL = CW'(LONG_TH + 1);
    localparam logic [CW-1:0] MIN_VAL = CW'(MIN_CLKS);
    localparam logic [CW-1:0] TH_VAL  = CW'(LONG_TH);

    logic [CW-1:0] cnt_q;

    // Count low samples, clear on a high sample, stop at saturation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!pin_low_i) begin
            cnt_q <= '0;
        end else if (cnt_q != SAT_VAL) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Threshold decodes of the registered count
    always_comb begin
        at_min_o  = (cnt_q >= MIN_VAL);
        is_long_o = (cnt_q > TH_VAL);
    end

    // R5
    width_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_low_i && $past(pin_low_i)) |-> (cnt_q >= $past(cnt_q)));

endmodule

// File: rtl/rstseq_cfg.sv
// Start-up configuration latch.
// A full latch takes the whole pin word. A partial latch keeps the
// clock-select field at the top of the word and takes the rest.
// While the power-on reset is active, the latch follows the pins.
module rstseq_cfg
    import rstseq_pkg::*;
#(
    parameter int CFG_W   = 16,
    parameter int SEL_LSB = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cfg_op_e          op_i,
    input  logic [CFG_W-1:0] pins_i,
    output logic [CFG_W-1:0] cfg_o
);
    logic [CFG_W-1:0] cfg_q;

    // Update the latched word according to the requested operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= pins_i;
        end else begin
            case (op_i)
                CFG_FULL: cfg_q <= pins_i;
                CFG_PART: cfg_q <= {cfg_q[CFG_W-1:SEL_LSB], pins_i[SEL_LSB-1:0]};
                default:  cfg_q <= cfg_q;
            endcase
        end
    end

    assign cfg_o = cfg_q;

    // R6
    sel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == CFG_PART) |=> (cfg_o[CFG_W-1:SEL_LSB] == $past(cfg_o[CFG_W-1:SEL_LSB])));

endmodule

// File: rtl/rstseq_flags.sv
// Reset source flags.
// A non-zero set vector replaces the whole flag word, which keeps it
// one-hot. Otherwise, bits written with ones are cleared.
// Power-on reset records the asynchronous source.
module rstseq_flags
    import rstseq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] flags_o
);
    logic [NSRC-1:0] flags_q;

    // Record a new source, otherwise apply the write-ones clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= NSRC'(1) << SRC_ASYNC;
        end else if (|set_i) begin
            flags_q <= set_i;
        end else begin
            flags_q <= flags_q & ~clr_i;
        end
    end

    assign flags_o = flags_q;

    // R10
    flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flags_o));

endmodule

// File: rtl/reset_sequencer.sv
// Reset source classifier and sequencer (top level).
// Handles an asynchronous or synchronous pin reset, depending on mode_i,
// and watchdog and software requests. It classifies each reset, records
// the source, latches the configuration and runs a fixed sequence.
// Assumes rstin_i is synchronized and reflects only external drivers.
module reset_sequencer
    import rstseq_pkg::*;
#(
    parameter int CFG_W      = 16,
    parameter int SEL_LSB    = 13,
    parameter int MIN_CLKS   = 25,
    parameter int LONG_CLKS  = 522,
    parameter int GRACE_CLKS = 6,
    parameter int SEQ_LEN    = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rstin_i,
    input  logic             mode_i,
    input  logic             sw_req_i,
    input  logic             wdt_req_i,
    input  logic             bidir_en_i,
    input  logic             busy_i,
    input  logic [CFG_W-1:0] cfg_pins_i,
    input  logic [4:0]       flag_clr_i,
    output logic             core_rst_o,
    output logic             abort_o,
    output logic             hold_cancel_o,
    output logic             rst_pull_o,
    output logic [CFG_W-1:0] cfg_o,
    output logic [4:0]       flags_o
);
    localparam int TMAX = (SEQ_LEN > GRACE_CLKS) ? SEQ_LEN : GRACE_CLKS;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] SEQ_LAST   = TW'(SEQ_LEN - 1);
    localparam logic [TW-1:0] GRACE_LAST = TW'(GRACE_CLKS - 1);

    seq_state_e      state_q, state_d;
    logic [TW-1:0]   tmr_q, tmr_d;
    logic            soft_q, soft_d;
    logic [NSRC-1:0] set_vec;
    cfg_op_e         cfg_op;
    logic            async_now;
    logic            at_min, is_long;

    // Asynchronous condition, decoded straight from the pins
    assign async_now = !mode_i && !rstin_i;

    rstseq_width #(
        .MIN_CLKS (MIN_CLKS),
        .LONG_CLKS(LONG_CLKS)
    ) u_width (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_low_i(!rstin_i),
        .at_min_o (at_min),
        .is_long_o(is_long)
    );

    rstseq_cfg #(
        .CFG_W  (CFG_W),
        .SEL_LSB(SEL_LSB)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .op_i  (cfg_op),
        .pins_i(cfg_pins_i),
        .cfg_o (cfg_o)
    );

    rstseq_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (flag_clr_i),
        .flags_o(flags_o)
    );

    // Next-state, source classification and latch control
    always_comb begin
        state_d = state_q;
        tmr_d   = tmr_q;
        soft_d  = soft_q;
        set_vec = '0;
        cfg_op  = CFG_KEEP;
        if (async_now) begin
            state_d = ST_ASYNC;
            tmr_d   = '0;
            soft_d  = 1'b0;
            set_vec[SRC_ASYNC] = 1'b1;
            cfg_op  = CFG_FULL;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (!rstin_i && mode_i && at_min) begin
                        state_d = ST_GRACE;
                        tmr_d   = '0;
                    end else if (wdt_req_i || sw_req_i) begin
                        state_d = ST_SEQ;
                        tmr_d   = '0;
                        soft_d  = 1'b1;
                        if (wdt_req_i) set_vec[SRC_WDT] = 1'b1;
                        else           set_vec[SRC_SW]  = 1'b1;
                    end
                end
                ST_GRACE, ST_HOLD: begin
                    if (rstin_i) begin
                        state_d = ST_SEQ;
                        tmr_d   = '0;
                        soft_d  = 1'b0;
                        if (is_long) begin
                            set_vec[SRC_LONG] = 1'b1;
                            cfg_op = CFG_FULL;
                        end else begin
                            set_vec[SRC_SHORT] = 1'b1;
                            cfg_op = CFG_PART;
                        end
                    end else if (state_q == ST_GRACE) begin
                        if (!busy_i || tmr_q == GRACE_LAST) begin
                            state_d = ST_HOLD;
                        end else begin
                            tmr_d = tmr_q + 1'b1;
                        end
                    end
                end
                ST_SEQ: begin
                    if (tmr_q == SEQ_LAST) begin
                        state_d = ST_IDLE;
                        tmr_d   = '0;
                    end else begin
                        tmr_d = tmr_q + 1'b1;
                    end
                end
                ST_ASYNC: begin
                    state_d = ST_SEQ;
                    tmr_d   = '0;
                    soft_d  = 1'b0;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State, timer and source-kind registers; power-on starts a sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SEQ;
            tmr_q   <= '0;
            soft_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
            soft_q  <= soft_d;
        end
    end

    // Output decodes: reset, abort, hold cancel and pin pull-down
    always_comb begin
        core_rst_o    = async_now || (state_q == ST_HOLD) ||
                        (state_q == ST_SEQ) || (state_q == ST_ASYNC);
        abort_o       = async_now;
        hold_cancel_o = async_now || (state_q == ST_GRACE);
        rst_pull_o    = bidir_en_i && (state_q == ST_SEQ) && (mode_i || !soft_q);
    end

    // R1
    async_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && !rstin_i) |=> core_rst_o);

    // R4
    grace_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_cancel_o && !busy_i && mode_i && !rstin_i) |=> core_rst_o);

    // R8
    seq_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEQ && tmr_q != SEQ_LAST) |=> core_rst_o);

    // R9
    pull_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pull_o |-> (bidir_en_i && core_rst_o && !abort_o));

endmodule

// File: tb/sim_reset_sequencer.sv
// Bench for reset_sequencer with a small configuration: sweeps every
// pulse width across both thresholds and measures timing in cycles.
module sim_reset_sequencer;
    localparam int MINC = 3;
    localparam int LONGC = 10;
    localparam int LTH = MINC + LONGC;
    localparam int GRC = 6;
    localparam int SEQ = 16;

    logic        clk = 1'b0;
    logic        rst_n, rstin, mode, sw_req, wdt_req, bidir, busy;
    logic [15:0] pins;
    logic [4:0]  fclr;
    logic        core_rst, abort_s, hcancel, pull;
    logic [15:0] cfg;
    logic [4:0]  flags;

    int tests = 0;
    int fails = 0;
    logic [15:0] exp_cfg;

    reset_sequencer #(
        .CFG_W(16), .SEL_LSB(13), .MIN_CLKS(MINC), .LONG_CLKS(LONGC),
        .GRACE_CLKS(GRC), .SEQ_LEN(SEQ)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .rstin_i(rstin), .mode_i(mode),
        .sw_req_i(sw_req), .wdt_req_i(wdt_req), .bidir_en_i(bidir),
        .busy_i(busy), .cfg_pins_i(pins), .flag_clr_i(fclr),
        .core_rst_o(core_rst), .abort_o(abort_s), .hold_cancel_o(hcancel),
        .rst_pull_o(pull), .cfg_o(cfg), .flags_o(flags)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Count cycles with the internal reset active, sampling at negedges
    task automatic measure(output int n);
        n = 0;
        while (core_rst === 1'b1 && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic clear_flags();
        fclr = 5'h1f;
        @(negedge clk);
        fclr = 5'h00;
    endtask

    task automatic soft_pulse(input logic w, input logic s);
        wdt_req = w;
        sw_req  = s;
        @(negedge clk);
        wdt_req = 1'b0;
        sw_req  = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        rst_n = 1'b0; rstin = 1'b1; mode = 1'b1; sw_req = 1'b0; wdt_req = 1'b0;
        bidir = 1'b1; busy = 1'b0; pins = 16'hA5C3; fclr = 5'h00;
        repeat (3) @(negedge clk);
        // R11: power-on state
        chk("R11 core_rst in reset", core_rst, 1);
        chk("R11 flags in reset", flags, 5'b00001);
        chk("R11 cfg follows pins", cfg, 16'hA5C3);
        rst_n = 1'b1;
        measure(n);
        chk("R11 sequence after power-on", n, SEQ);
        exp_cfg = 16'hA5C3;

        // R3 R5 R6 R8 R9: sweep of synchronous pulse widths
        for (int w = 1; w <= LTH + 3; w++) begin
            logic [15:0] p;
            logic [4:0]  ef;
            clear_flags();
            p = 16'(w * 16'h2F3B) ^ 16'h6000;
            pins = p;
            rstin = 1'b0;
            repeat (w) @(negedge clk);
            rstin = 1'b1;
            @(negedge clk);
            if (w > LTH) begin
                exp_cfg = p; ef = 5'b00010;
            end else if (w > MINC) begin
                exp_cfg = {exp_cfg[15:13], p[12:0]}; ef = 5'b00100;
            end else begin
                ef = 5'b00000;
            end
            if (w > MINC) chk("R9 pull during sequence", pull, 1);
            measure(n);
            chk(w > MINC ? "R8 sequence length" : "R3 short glitch ignored", n, (w > MINC) ? SEQ : 0);
            chk(w > LTH ? "R5 long flag" : (w > MINC ? "R5 short flag" : "R3 no flag"), flags, ef);
            chk(w > LTH ? "R6 full latch" : (w > MINC ? "R6 select kept" : "R3 cfg untouched"), cfg, exp_cfg);
        end

        // R4: grace window with the bus busy and idle
        for (int b = 1; b >= 0; b--) begin
            int k, kh, ab;
            busy = b[0];
            k = 0; kh = 0; ab = 0;
            rstin = 1'b0;
            while (core_rst !== 1'b1 && k < 50) begin
                @(negedge clk);
                k++;
                if (hcancel === 1'b1 && kh == 0) kh = k;
                if (abort_s === 1'b1) ab++;
            end
            chk("R4 hold cancel start", kh, MINC + 1);
            chk("R4 reset after grace", k, b ? (MINC + 1 + GRC) : (MINC + 2));
            chk("R1 no abort in sync mode", ab, 0);
            rstin = 1'b1;
            @(negedge clk);
            measure(n);
            chk("R8 sequence after grace", n, SEQ);
        end
        busy = 1'b0;

        // R1 R2 R6: asynchronous reset
        clear_flags();
        mode = 1'b0;
        pins = 16'hE00F;
        rstin = 1'b0;
        #1;
        chk("R1 immediate core reset", core_rst, 1);
        chk("R1 immediate abort", abort_s, 1);
        chk("R1 immediate hold cancel", hcancel, 1);
        repeat (3) @(negedge clk);
        chk("R2 async flag", flags, 5'b00001);
        rstin = 1'b1;
        #1;
        chk("R1 abort drops on release", abort_s, 0);
        @(negedge clk);
        chk("R9 pull after async", pull, 1);
        measure(n);
        chk("R2 sequence after async", n, SEQ);
        chk("R6 async full latch", cfg, 16'hE00F);
        exp_cfg = 16'hE00F;
        pins = 16'h1234;

        // R7 R9: watchdog in sync mode, software in async mode
        mode = 1'b1;
        clear_flags();
        soft_pulse(1'b1, 1'b0);
        chk("R9 pull for watchdog", pull, 1);
        measure(n);
        chk("R7 watchdog sequence", n, SEQ);
        chk("R7 watchdog flag", flags, 5'b01000);
        chk("R7 cfg unchanged", cfg, exp_cfg);
        mode = 1'b0;
        soft_pulse(1'b0, 1'b1);
        chk("R9 no pull for software in async mode", pull, 0);
        measure(n);
        chk("R7 software flag", flags, 5'b10000);
        mode = 1'b1;
        bidir = 1'b0;
        soft_pulse(1'b1, 1'b0);
        chk("R9 no pull when disabled", pull, 0);
        measure(n);
        bidir = 1'b1;

        // R7: watchdog beats software
        soft_pulse(1'b1, 1'b1);
        measure(n);
        chk("R7 priority", flags, 5'b01000);

        // R12: requests during a sequence are ignored
        soft_pulse(1'b0, 1'b1);
        soft_pulse(1'b1, 1'b0);
        measure(n);
        chk("R12 sequence not extended", n, SEQ - 1);
        chk("R12 flags unchanged", flags, 5'b10000);

        // R10: write-ones clear and set priority
        fclr = 5'b01111;
        @(negedge clk);
        chk("R10 other bits clear nothing", flags, 5'b10000);
        fclr = 5'b10000;
        @(negedge clk);
        fclr = 5'b00000;
        chk("R10 clear", flags, 5'b00000);
        fclr = 5'h1f;
        soft_pulse(1'b0, 1'b1);
        fclr = 5'h00;
        chk("R10 set beats clear", flags, 5'b10000);
        measure(n);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule